// File: doc/BRIEF.md
# Byte-Lane SRAM Array Core

This block is a clock-synchronous functional model of a 16-bit-wide static RAM with 2^AW words. The address width is a parameter: 19 bits gives the full 512K-word array, and a small value keeps simulation light. Two chip selects of opposite polarity must both be active for any access. Independent upper and lower byte enables decide which half of the word is stored or presented.

On every rising clock edge the core decodes the control inputs into a write, a read, or standby. A write stores the enabled byte lanes at the addressed word and leaves the other lane unchanged. A read registers the enabled lanes of the addressed word. It raises a per-lane drive flag that a tri-state wrapper at the chip edge uses to control the pads. A lane that is not driven shows zeros on the data output. Write enable takes priority over output enable: during any write cycle no lane drives.

Top module: `byte_lane_sram`

## Requirements
- R1: The core is selected only when `selN` is 0 and `selP` is 1. With either select inactive, no write changes the array and both `laneDrive` bits are 0 one cycle later.
- R2: When `upperN` and `lowerN` are both 1, the core is treated as deselected: nothing is written and both `laneDrive` bits are 0 one cycle later.
- R3: When selected with `wrN` = 0, the rising edge stores `wrData[7:0]` if `lowerN` = 0 and stores `wrData[15:8]` if `upperN` = 0. A lane whose enable is 1 keeps its previous contents.
- R4: When selected with `oeN` = 0 and `wrN` = 1, the addressed word is read. One clock later `laneDrive[0]` is 1 if `lowerN` was 0, and `laneDrive[1]` is 1 if `upperN` was 0. Each driven lane shows its stored byte: bits 7:0 for the lower lane, bits 15:8 for the upper lane.
- R5: Any lane whose `laneDrive` bit is 0 shows 0 on its byte of `rdData`.
- R6: When `oeN` is 1, both `laneDrive` bits are 0 one cycle later.
- R7: When `wrN` = 0 and `oeN` = 0 in the same cycle, the write of R3 takes place and both `laneDrive` bits are 0 one cycle later.
- R8: While `rstN` is 0, `laneDrive` and `rdData` are 0.
- R9: A read in the cycle right after a write to the same address returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | AW | Word address |
| selN | input | 1 | Active-low chip select |
| selP | input | 1 | Active-high chip select |
| wrN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| upperN | input | 1 | Active-low enable for bits 15:8 |
| lowerN | input | 1 | Active-low enable for bits 7:0 |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data, zero on undriven lanes |
| laneDrive | output | 2 | Per-lane output drive flag (bit 0 lower, bit 1 upper) |

## Verification
Write enable and output enable can both be asserted in the same cycle. That cycle must perform the write and must leave both lanes undriven. The random stimulus sets both signals low on a large share of cycles. Directed cases pair a combined write and output-enable cycle with a read of the same word in the next cycle. The bench judges such a cycle twice: the drive flags must be zero in the following cycle, and the bench's model of the array must match the data returned by the read that follows.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Strobes passed from decode to datapath, one bit per byte lane
  typedef struct packed {
    logic [LANES-1:0] wrLane;
    logic [LANES-1:0] rdLane;
  } ctlStrobes_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             selN,
  input  logic             selP,
  input  logic             wrN,
  input  logic             oeN,
  input  logic [LANES-1:0] byteEnN,
  output ctlStrobes_t      strobes
);
  logic anyLane;
  logic chipOn;
  logic doWrite;
  logic doRead;

  always_comb begin
    anyLane = ~(&byteEnN);
    chipOn  = ~selN & selP & anyLane;
    doWrite = chipOn & ~wrN;
    doRead  = chipOn & wrN & ~oeN;
    for (int i = 0; i < LANES; i++) begin
      strobes.wrLane[i] = doWrite & ~byteEnN[i];
      strobes.rdLane[i] = doRead & ~byteEnN[i];
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     addr,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LANES-1:0]  laneDrive
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrLane[g]) laneMem[addr] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[g*LANE_W +: LANE_W] <= '0;
        laneDrive[g] <= 1'b0;
      end else begin
        rdData[g*LANE_W +: LANE_W] <= strobes.rdLane[g] ? laneMem[addr] : '0;
        laneDrive[g] <= strobes.rdLane[g];
      end
    end
  end
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          selN,
  input  logic          selP,
  input  logic          wrN,
  input  logic          oeN,
  input  logic          upperN,
  input  logic          lowerN,
  input  logic [15:0]   wrData,
  output logic [15:0]   rdData,
  output logic [1:0]    laneDrive
);
  ctlStrobes_t strobes;

  sram_ctrl u_ctrl (
    .selN    (selN),
    .selP    (selP),
    .wrN     (wrN),
    .oeN     (oeN),
    .byteEnN ({upperN, lowerN}),
    .strobes (strobes)
  );

  sram_datapath #(.AW(AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .strobes   (strobes),
    .wrData    (wrData),
    .rdData    (rdData),
    .laneDrive (laneDrive)
  );
endmodule

// File: rtl/sram_checker.sv
module sram_checker (
  input logic        clk,
  input logic        rstN,
  input logic        selN,
  input logic        selP,
  input logic        wrN,
  input logic        oeN,
  input logic        upperN,
  input logic        lowerN,
  input logic [15:0] rdData,
  input logic [1:0]  laneDrive
);
  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selN || !selP) |=> (laneDrive == 2'b00));

  assert_no_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (upperN && lowerN) |=> (laneDrive == 2'b00));

  assert_read_lower_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && selP && wrN && !oeN && !lowerN) |=> laneDrive[0]);

  assert_read_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && selP && wrN && !oeN && !upperN) |=> laneDrive[1]);

  assert_zero_lower_R5: assert property (@(posedge clk) disable iff (!rstN)
    !laneDrive[0] |-> (rdData[7:0] == 8'h00));

  assert_zero_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    !laneDrive[1] |-> (rdData[15:8] == 8'h00));

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (laneDrive == 2'b00));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |=> (laneDrive == 2'b00));
endmodule

bind byte_lane_sram sram_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .selN      (selN),
  .selP      (selP),
  .wrN       (wrN),
  .oeN       (oeN),
  .upperN    (upperN),
  .lowerN    (lowerN),
  .rdData    (rdData),
  .laneDrive (laneDrive)
);

// File: tb/byte_lane_sram_tb.sv
module byte_lane_sram_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          selN = 1'b1, selP = 1'b0, wrN = 1'b1, oeN = 1'b1;
  logic          upperN = 1'b1, lowerN = 1'b1;
  logic [15:0]   wrData = '0;
  logic [15:0]   rdData;
  logic [1:0]    laneDrive;

  logic [15:0] model [DEPTH];
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  byte_lane_sram #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .selP(selP),
    .wrN(wrN), .oeN(oeN), .upperN(upperN), .lowerN(lowerN),
    .wrData(wrData), .rdData(rdData), .laneDrive(laneDrive)
  );

  function automatic logic [1:0] expDrive(logic sN, logic sP, logic w, logic o,
                                          logic uN, logic lN);
    logic rd;
    rd = !sN && sP && !(uN && lN) && w && !o;
    return {rd && !uN, rd && !lN};
  endfunction

  function automatic logic [1:0] expWrite(logic sN, logic sP, logic w,
                                          logic uN, logic lN);
    logic wr;
    wr = !sN && sP && !(uN && lN) && !w;
    return {wr && !uN, wr && !lN};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; checks at the next falling edge
  task automatic cycle(logic [AW-1:0] a, logic sN, logic sP, logic w, logic o,
                       logic uN, logic lN, logic [15:0] d, string tag);
    logic [1:0]  eDrv, eWr;
    logic [15:0] eData;
    addr = a; selN = sN; selP = sP; wrN = w; oeN = o;
    upperN = uN; lowerN = lN; wrData = d;
    eDrv = expDrive(sN, sP, w, o, uN, lN);
    eWr  = expWrite(sN, sP, w, uN, lN);
    eData = {eDrv[1] ? model[a][15:8] : 8'h00, eDrv[0] ? model[a][7:0] : 8'h00};
    if (eWr[0]) model[a][7:0]  = d[7:0];
    if (eWr[1]) model[a][15:8] = d[15:8];
    @(negedge clk);
    check({tag, " drive"}, {30'd0, laneDrive}, {30'd0, eDrv});
    check({tag, " data/R5"}, {16'd0, rdData}, {16'd0, eData});
  endtask

  function automatic string classify(logic sN, logic sP, logic w, logic o,
                                     logic uN, logic lN);
    if (sN || !sP) return "R1";
    if (uN && lN) return "R2";
    if (!w) return o ? "R3" : "R7";
    if (o) return "R6";
    return "R4";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    check("R8 reset drive", {30'd0, laneDrive}, 32'd0);
    check("R8 reset data", {16'd0, rdData}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Fill the array with full-word writes
    for (int i = 0; i < DEPTH; i++)
      cycle(AW'(i), 0, 1, 0, 1, 0, 0, 16'(i * 16'h0101 ^ 16'h5A3C), "R3 fill");

    // Directed: lower-only write keeps upper byte
    cycle(AW'(5), 0, 1, 0, 1, 1, 0, 16'hAAEE, "R3 lower only");
    cycle(AW'(5), 0, 1, 1, 0, 0, 0, 16'h0000, "R9 read after write");
    cycle(AW'(6), 0, 1, 0, 1, 0, 1, 16'hC3FF, "R3 upper only");
    cycle(AW'(6), 0, 1, 1, 0, 0, 0, 16'h0000, "R9 read after write");
    // Directed: write and output enable together
    cycle(AW'(7), 0, 1, 0, 0, 0, 0, 16'h1234, "R7 write wins");
    cycle(AW'(7), 0, 1, 1, 0, 0, 0, 16'h0000, "R7 readback");
    // Directed: each kind of deselect blocks write
    cycle(AW'(8), 1, 1, 0, 0, 0, 0, 16'hDEAD, "R1 selN high");
    cycle(AW'(8), 0, 0, 0, 0, 0, 0, 16'hBEEF, "R1 selP low");
    cycle(AW'(8), 0, 1, 0, 0, 1, 1, 16'hF00D, "R2 no lanes");
    cycle(AW'(8), 0, 1, 1, 0, 0, 0, 16'h0000, "R1 readback");
    // Directed: single-lane reads and output enable off
    cycle(AW'(9), 0, 1, 1, 0, 1, 0, 16'h0000, "R4 lower lane");
    cycle(AW'(9), 0, 1, 1, 0, 0, 1, 16'h0000, "R4 upper lane");
    cycle(AW'(9), 0, 1, 1, 1, 0, 0, 16'h0000, "R6 oe high");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic sN, sP, w, o, uN, lN;
      sN = ($urandom % 8) == 0;
      sP = ($urandom % 8) != 0;
      w  = ($urandom % 3) != 0;
      o  = ($urandom % 4) == 0;
      uN = ($urandom % 3) == 0;
      lN = ($urandom % 3) == 0;
      cycle(AW'($urandom % DEPTH), sN, sP, w, o, uN, lN, 16'($urandom),
            classify(sN, sP, w, o, uN, lN));
    end

    // Reset again mid-run
    rstN = 1'b0;
    #1;
    check("R8 reset drive", {30'd0, laneDrive}, 32'd0);
    check("R8 reset data", {16'd0, rdData}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule